// File: doc/BRIEF.md
# Per-Processor Local Interrupt Register Block

This block keeps the seven core-local interrupt sources of every processor in a small cluster. The sources are watchdog, counter-compare, core timer, performance counter, two software interrupts and debug channel. For each processor it holds an enable mask, which software changes through separate set and clear writes, and it reports which sources are pending. Each source has its own routing register, which steers it onto one interrupt pin of that processor.

The block answers on a simple request bus. Each request carries the number of the processor that issued it. Two address windows reach the same register layout:

- **Own window.** Addresses the requester's own registers.
- **Redirect window.** Addresses the registers of whichever processor the requester has placed in its selector register.

With the redirect window, one core can set up another core's local interrupts without a global lock. Reads return data one cycle after the request.

Top module: `lirq_block`

## Requirements
- R1: After synchronous reset every mask, control, route and selector register is zero, `pend_o` and `pin_o` are zero, and `rd_valid` is low.
- R2: Byte addresses 0x8000–0xBFFF (address bits 16:14 = 010) target the register set of processor `bus_id`. Addresses 0xC000–0xFFFF (bits 16:14 = 011) target the processor named in `bus_id`'s selector. Any other address changes no register, and a read of it returns 0.
- R3: The source numbering is watchdog 0, compare 1, core timer 2, performance counter 3, software 0 at 4, software 1 at 5 and debug channel 6.
  - A write to offset 0x010 sets the mask bits where `bus_wdata[6:0]` is 1.
  - A write to offset 0x00C clears the mask bits where `bus_wdata[6:0]` is 1.
  - Zero bits and bits 31:7 have no effect.
  - Offset 0x008 reads the mask in bits 6:0.
- R4: Offset 0x004 reads raw request AND mask in bits 6:0. `pend_o[p*7+s]` shows the same value one cycle after the raw request and the mask.
- R5: Route register s sits at offset 0x040+4*s. Bit 31 is the route enable and bits 5:0 are the pin number. A read returns only those bits.
- R6: Control at offset 0x000 stores bits 4:0 and returns them on a read. Each routable flag lets a group of sources reach the pins:
  - bit 1 lets the core timer reach the pins;
  - bit 2 lets the performance counter reach the pins;
  - bit 3 lets both software interrupts reach the pins;
  - bit 4 lets the debug channel reach the pins.
  Watchdog and compare can always be routed.
- R7: `pin_o[p*NPIN+k]` is registered. It is high when some source of processor p is pending, routable, has its route enabled and names pin k. A pin number of NPIN or more drives no pin.
- R8: Offset 0x080 holds each processor's selector in bits 5:0. Offset 0x088 is read-only and returns `bus_id` in bits 5:0.
- R9: If `bus_id` or the redirect target is NPROC or more, writes change nothing and reads return 0.
- R10: A read request raises `rd_valid` with `rd_data` in the following cycle. A write does not raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_id | input | 6 | Number of the requesting processor |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| src_raw | input | NPROC*7 | Raw local interrupt requests, 7 per processor |
| pend_o | output | NPROC*7 | Registered pending vector |
| pin_o | output | NPROC*NPIN | Registered interrupt pins |

## Verification
The assertions take for granted that the bus carries at most one request per cycle. They also assume that the bus inputs are idle, with zero values, while reset is held, so that a past value sampled during reset never looks like a request. The bench drives every request for exactly one cycle at the falling edge and returns all bus inputs to zero afterwards. It changes the raw requests only while no read of the pending register is in flight.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int NSRC   = 7;
  localparam int PID_W  = 6;
  localparam int DW     = 32;
  localparam int WIDX_W = 12;

  // word offsets inside a window
  localparam logic [WIDX_W-1:0] W_CTL   = 12'd0;
  localparam logic [WIDX_W-1:0] W_PEND  = 12'd1;
  localparam logic [WIDX_W-1:0] W_MASK  = 12'd2;
  localparam logic [WIDX_W-1:0] W_CLR   = 12'd3;
  localparam logic [WIDX_W-1:0] W_SET   = 12'd4;
  localparam logic [WIDX_W-1:0] W_ROUTE = 12'd16;
  localparam logic [WIDX_W-1:0] W_SEL   = 12'd32;
  localparam logic [WIDX_W-1:0] W_IDENT = 12'd34;

  typedef enum logic [2:0] {
    SRC_WDOG  = 3'd0,
    SRC_CMP   = 3'd1,
    SRC_TIMER = 3'd2,
    SRC_PERF  = 3'd3,
    SRC_SW0   = 3'd4,
    SRC_SW1   = 3'd5,
    SRC_DBG   = 3'd6
  } src_e;
endpackage

// File: rtl/lirq_vp_regs.sv
module lirq_vp_regs
  import lirq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [WIDX_W-1:0]           word,
  input  logic [DW-1:0]               wdata,
  output logic [4:0]                  ctl,
  output logic [NSRC-1:0]             mask,
  output logic [PID_W-1:0]            sel,
  output logic [NSRC-1:0]             route_en,
  output logic [NSRC-1:0][PID_W-1:0]  route_pin
);
  logic set_we, clr_we;
  assign set_we = we && (word == W_SET);
  assign clr_we = we && (word == W_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      mask <= '0;
      sel  <= '0;
    end else begin
      if (we && word == W_CTL) ctl <= wdata[4:0];
      if (we && word == W_SEL) sel <= wdata[PID_W-1:0];
      if (set_we)      mask <= mask | wdata[NSRC-1:0];
      else if (clr_we) mask <= mask & ~wdata[NSRC-1:0];
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst) begin
        route_en[s]  <= 1'b0;
        route_pin[s] <= '0;
      end else if (we && word == W_ROUTE + WIDX_W'(s)) begin
        route_en[s]  <= wdata[31];
        route_pin[s] <= wdata[PID_W-1:0];
      end
    end
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0]))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((mask & $past(wdata[NSRC-1:0])) == '0)); // R3
endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NSRC-1:0]             raw,
  input  logic [NSRC-1:0]             mask,
  input  logic [4:0]                  ctl,
  input  logic [NSRC-1:0]             route_en,
  input  logic [NSRC-1:0][PID_W-1:0]  route_pin,
  output logic [NSRC-1:0]             pend_q,
  output logic [NPIN-1:0]             pin_q
);
  logic [NSRC-1:0] pend_c, routable, live;
  logic [NPIN-1:0] pin_c;

  assign pend_c   = raw & mask;
  assign routable = {ctl[4], ctl[3], ctl[3], ctl[2], ctl[1], 2'b11};
  assign live     = pend_c & route_en & routable;

  always_comb begin
    pin_c = '0;
    for (int k = 0; k < NPIN; k++)
      for (int s = 0; s < NSRC; s++)
        if (live[s] && route_pin[s] == PID_W'(k)) pin_c[k] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      pin_q  <= '0;
    end else begin
      pend_q <= pend_c;
      pin_q  <= pin_c;
    end
  end

  AST_PIN_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
    (|pin_q) |-> $past(|(pend_c & route_en))); // R7
endmodule

// File: rtl/lirq_block.sv
module lirq_block
  import lirq_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NPIN   = 8,
  parameter int ADDR_W = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  input  logic [PID_W-1:0]        bus_id,
  output logic                    rd_valid,
  output logic [DW-1:0]           rd_data,
  input  logic [NPROC*NSRC-1:0]   src_raw,
  output logic [NPROC*NSRC-1:0]   pend_o,
  output logic [NPROC*NPIN-1:0]   pin_o
);
  logic [2:0]        win;
  logic              is_loc, is_red, id_ok, tgt_ok;
  logic [WIDX_W-1:0] word;
  logic [PID_W-1:0]  selv, tgt;
  logic [DW-1:0]     rdata_c;

  logic [NPROC-1:0][4:0]                  ctl;
  logic [NPROC-1:0][NSRC-1:0]             mask;
  logic [NPROC-1:0][PID_W-1:0]            sel;
  logic [NPROC-1:0][NSRC-1:0]             route_en;
  logic [NPROC-1:0][NSRC-1:0][PID_W-1:0]  route_pin;

  assign win    = bus_addr[16:14];
  assign word   = bus_addr[13:2];
  assign is_loc = (win == 3'b010);
  assign is_red = (win == 3'b011);
  assign id_ok  = (32'(bus_id) < NPROC);

  always_comb begin
    selv = '0;
    for (int p = 0; p < NPROC; p++)
      if (bus_id == PID_W'(p)) selv = sel[p];
  end

  assign tgt    = is_loc ? bus_id : selv;
  assign tgt_ok = id_ok && (is_loc || is_red) && (32'(tgt) < NPROC);

  for (genvar p = 0; p < NPROC; p++) begin : g_vp
    logic we;
    assign we = bus_valid && bus_write && tgt_ok && (tgt == PID_W'(p));

    lirq_vp_regs i_regs (
      .clk(clk), .rst(rst), .we(we), .word(word), .wdata(bus_wdata),
      .ctl(ctl[p]), .mask(mask[p]), .sel(sel[p]),
      .route_en(route_en[p]), .route_pin(route_pin[p])
    );

    lirq_router #(.NPIN(NPIN)) i_router (
      .clk(clk), .rst(rst), .raw(src_raw[p*NSRC +: NSRC]), .mask(mask[p]),
      .ctl(ctl[p]), .route_en(route_en[p]), .route_pin(route_pin[p]),
      .pend_q(pend_o[p*NSRC +: NSRC]), .pin_q(pin_o[p*NPIN +: NPIN])
    );
  end

  always_comb begin
    rdata_c = '0;
    for (int p = 0; p < NPROC; p++) begin
      if (tgt_ok && tgt == PID_W'(p)) begin
        if (word == W_CTL)       rdata_c[4:0] = ctl[p];
        else if (word == W_PEND) rdata_c[NSRC-1:0] = src_raw[p*NSRC +: NSRC] & mask[p];
        else if (word == W_MASK) rdata_c[NSRC-1:0] = mask[p];
        else if (word == W_SEL)  rdata_c[PID_W-1:0] = sel[p];
        else if (word == W_IDENT) rdata_c[PID_W-1:0] = bus_id;
        else if (word >= W_ROUTE && word < W_ROUTE + WIDX_W'(NSRC)) begin
          rdata_c[31]          = route_en[p][word[2:0]];
          rdata_c[PID_W-1:0]   = route_pin[p][word[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      rd_data  <= (bus_valid && !bus_write) ? rdata_c : '0;
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_valid && !bus_write)); // R10
  AST_WR_NO_RD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write) |=> !rd_valid); // R10
  AST_BAD_WIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !(is_loc || is_red)) |=> (rd_data == '0)); // R2
  AST_BAD_TGT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !tgt_ok) |=> (rd_data == '0)); // R9
endmodule

// File: tb/test_lirq_block.sv
module test_lirq_block;
  localparam int NPROC = 4;
  localparam int NPIN  = 8;
  localparam int NSRC  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [16:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [5:0]  bus_id = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [NPROC*NSRC-1:0] src_raw = '0;
  logic [NPROC*NSRC-1:0] pend_o;
  logic [NPROC*NPIN-1:0] pin_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lirq_block #(.NPROC(NPROC), .NPIN(NPIN), .ADDR_W(17)) i_lirq_block (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_id(bus_id),
    .rd_valid(rd_valid), .rd_data(rd_data), .src_raw(src_raw),
    .pend_o(pend_o), .pin_o(pin_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [5:0] id, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_id = id; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_id = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [16:0] a, input logic [5:0] id, input logic [31:0] exp,
                    input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_id = id;
    @(negedge clk);
    bus_valid = 1'b0; bus_addr = '0; bus_id = '0;
    check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
    check(req, rd_data, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pend_o", 32'(pend_o), 32'd0);
    check("R1 pin_o", 32'(pin_o), 32'd0);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    rd(17'h08008, 6'd0, 32'd0, "R1 mask");
    rd(17'h08000, 6'd2, 32'd0, "R1 ctl");
    rd(17'h08040, 6'd1, 32'd0, "R1 route");
    rd(17'h08080, 6'd3, 32'd0, "R1 selector");
  endtask

  task automatic t_mask();
    wr(17'h08010, 6'd1, 32'h55);
    rd(17'h08008, 6'd1, 32'h55, "R3 set mask");
    wr(17'h0800C, 6'd1, 32'h05);
    rd(17'h08008, 6'd1, 32'h50, "R3 clear mask");
    wr(17'h08010, 6'd1, 32'hFFFF_FF80);
    rd(17'h08008, 6'd1, 32'h50, "R3 upper bits ignored");
    wr(17'h0800C, 6'd1, 32'hFFFF_FF80);
    check("R10 write gives no rd_valid", 32'(rd_valid), 32'd0);
    rd(17'h08008, 6'd1, 32'h50, "R3 clear upper bits ignored");
  endtask

  task automatic t_pend();
    src_raw[1*NSRC +: NSRC] = 7'h7F;
    settle();
    rd(17'h08004, 6'd1, 32'h50, "R4 pending read");
    check("R4 pend_o", 32'(pend_o[1*NSRC +: NSRC]), 32'h50);
  endtask

  task automatic t_route();
    wr(17'h08040, 6'd1, 32'hFFFF_FFC3);
    rd(17'h08040, 6'd1, 32'h8000_0003, "R5 route readback");
    wr(17'h08010, 6'd1, 32'h07);
    wr(17'h08048, 6'd1, 32'h8000_0005);
    wr(17'h08044, 6'd1, 32'h8000_0009);
    settle();
    check("R6 timer blocked, R7 wdog on pin3", 32'(pin_o[1*NPIN +: NPIN]), 32'h08);
    wr(17'h08000, 6'd1, 32'hFFFF_FFFF);
    rd(17'h08000, 6'd1, 32'h1F, "R6 control bits");
    wr(17'h08000, 6'd1, 32'h02);
    settle();
    check("R7 timer routed to pin5", 32'(pin_o[1*NPIN +: NPIN]), 32'h28);
    check("R7 other processors quiet", 32'(pin_o[0 +: NPIN]), 32'h00);
  endtask

  task automatic t_redirect();
    wr(17'h08080, 6'd0, 32'h2);
    rd(17'h08080, 6'd0, 32'h2, "R8 selector readback");
    wr(17'h0C010, 6'd0, 32'h21);
    rd(17'h08008, 6'd2, 32'h21, "R2 redirect reached proc2");
    rd(17'h08008, 6'd0, 32'h00, "R2 own mask untouched");
    rd(17'h0C008, 6'd0, 32'h21, "R2 redirect read");
    rd(17'h08088, 6'd3, 32'h3, "R8 identity");
    wr(17'h08088, 6'd3, 32'h15);
    rd(17'h08088, 6'd3, 32'h3, "R8 identity read-only");
  endtask

  task automatic t_bad();
    wr(17'h08080, 6'd0, 32'h7);
    wr(17'h0C010, 6'd0, 32'h7F);
    rd(17'h0C008, 6'd0, 32'h0, "R9 bad redirect target read");
    rd(17'h08008, 6'd0, 32'h00, "R9 proc0 mask");
    rd(17'h08008, 6'd1, 32'h57, "R9 proc1 mask");
    rd(17'h08008, 6'd2, 32'h21, "R9 proc2 mask");
    rd(17'h08008, 6'd3, 32'h00, "R9 proc3 mask");
    wr(17'h08010, 6'd5, 32'h7F);
    rd(17'h08008, 6'd5, 32'h0, "R9 bad requester");
    wr(17'h00010, 6'd3, 32'h7F);
    rd(17'h08008, 6'd3, 32'h00, "R2 outside window no write");
    rd(17'h00008, 6'd1, 32'h0, "R2 outside window reads zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mask();
    t_pend();
    t_route();
    t_redirect();
    t_bad();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule